// File: doc/BRIEF.md
# SDRAM Start-Up Sequencer

This block takes a synchronous DRAM from reset to a usable state. While the sequence runs it owns the command pins, the address and the bank select. When reset is released it keeps the bus in NOP with clock enable and data mask both high. That pause lasts long enough to cover the device's required power-on wait. It then issues a precharge of every bank and waits for precharge recovery. Next come a fixed number of auto-refresh commands and one mode-register write. A parameter chooses whether the refreshes come before or after the mode-register write. The mode-register value holds the configured burst length, burst type and CAS latency.

Each delay is given in nanoseconds and converted to a whole number of cycles using the clock period. Every command lasts one cycle and is followed by NOP. Once the wait after the final command has run out, `init_done` rises and holds. From then on the bus stays idle, and the controller that follows takes over the pins. This block does not schedule refreshes during normal operation and does not touch the DQ bus.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low: the command pins read NOP, `sd_cke` and `sd_dqm` are high, address and bank are zero, and `init_done` is low. NOP means {cs_n,ras_n,cas_n,we_n} = 0111.
- R2: After reset is released, cycle 0 is the first output cycle. Cycles 0 to PAUSE-1 present NOP with `sd_cke` and `sd_dqm` high.
- R3: In cycle PAUSE the command is precharge-all: {cs_n,ras_n,cas_n,we_n} = 0010, address bit 10 high, all other address bits zero, bank zero.
- R4: NUM_REF auto-refresh commands ({cs_n,ras_n,cas_n,we_n} = 0001, `sd_cke` high, address zero) are issued RC cycles apart. The command after the precharge comes RP cycles after it.
- R5: With REF_BEFORE_MRS = 1 the order is precharge, refreshes, mode write. With REF_BEFORE_MRS = 0 it is precharge, mode write, refreshes.
- R6: The mode write is {cs_n,ras_n,cas_n,we_n} = 0000 with bank zero. The address is burst length code in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, and zero above.
- R7: After the mode write, the next command or the rise of `init_done` comes exactly RSC cycles later.
- R8: Every command lasts exactly one cycle. The cycle after any command is NOP, and address and bank are zero whenever the bus is at NOP.
- R9: `init_done` rises G cycles after the last command, where G is the wait that follows that command. It stays high until reset. From then on the bus is NOP, `sd_cke` is high and `sd_dqm` is low.
- R10: Each cycle count is ceil(time_ns × 1000 / CLK_PERIOD_PS), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | Clock enable to the DRAM |
| sd_dqm | output | 1 | Data mask; high until start-up completes |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address; carries bit 10 for precharge-all and the mode value |
| sd_ba | output | BA_W | Bank select, zero throughout |
| init_done | output | 1 | High once the sequence has finished |

## Verification
The hardest things to reach from the ports are the two command orders and the exact cycle on which each wait ends. The power-on pause alone would hide every later edge for tens of thousands of cycles. The bench therefore builds two instances with short timing parameters and opposite ordering, and it includes a fractional period (16.5 cycles) to test rounding up. A behavioural schedule of expected command cycles, built from the requirements, is compared with both instances on every cycle. Dedicated checks then look at the cycles just before and just after each wait ends.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command pins packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE_WAIT,
    ST_REF_WAIT,
    ST_MRS_WAIT,
    ST_DONE
  } init_st_e;

  function automatic int unsigned ns_to_cyc(int unsigned t_ns, int unsigned per_ps);
    int unsigned c;
    c = (t_ns * 1000 + per_ps - 1) / per_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= CNT_W'(RST_VAL);
    else if (load)     count_q <= load_val;
    else if (!expired) count_q <= count_q - 1'b1;
  end

  assign expired = (count_q == '0);

  // R10
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned NUM_REF        = 8,
  parameter bit          REF_BEFORE_MRS = 1'b1,
  parameter int unsigned RP_CYC         = 5,
  parameter int unsigned RC_CYC         = 15,
  parameter int unsigned RSC_CYC        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expired,
  output logic             issue,
  output sd_cmd_e          cmd,
  output logic [CNT_W-1:0] gap,
  output logic             done
);
  localparam int unsigned REF_CW = $clog2(NUM_REF + 1);
  localparam logic [CNT_W-1:0] RP_GAP  = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] RC_GAP  = CNT_W'(RC_CYC - 1);
  localparam logic [CNT_W-1:0] RSC_GAP = CNT_W'(RSC_CYC - 1);
  localparam logic [REF_CW-1:0] REF_LAST = REF_CW'(NUM_REF);

  init_st_e          state_q, state_d;
  logic [REF_CW-1:0] ref_q, ref_d;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    ref_d   = ref_q;
    done_d  = done_q;
    issue   = 1'b0;
    cmd     = CMD_NOP;
    gap     = '0;
    if (expired) begin
      unique case (state_q)
        ST_PAUSE: begin
          issue = 1'b1; cmd = CMD_PRE; gap = RP_GAP; state_d = ST_PRE_WAIT;
        end
        ST_PRE_WAIT: begin
          issue = 1'b1;
          if (REF_BEFORE_MRS) begin
            cmd = CMD_REF; gap = RC_GAP; ref_d = REF_CW'(1); state_d = ST_REF_WAIT;
          end else begin
            cmd = CMD_MRS; gap = RSC_GAP; state_d = ST_MRS_WAIT;
          end
        end
        ST_REF_WAIT: begin
          if (ref_q < REF_LAST) begin
            issue = 1'b1; cmd = CMD_REF; gap = RC_GAP; ref_d = ref_q + 1'b1;
          end else if (REF_BEFORE_MRS) begin
            issue = 1'b1; cmd = CMD_MRS; gap = RSC_GAP; state_d = ST_MRS_WAIT;
          end else begin
            done_d = 1'b1; state_d = ST_DONE;
          end
        end
        ST_MRS_WAIT: begin
          if (REF_BEFORE_MRS) begin
            done_d = 1'b1; state_d = ST_DONE;
          end else begin
            issue = 1'b1; cmd = CMD_REF; gap = RC_GAP; ref_d = REF_CW'(1); state_d = ST_REF_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAUSE;
      ref_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  // R4
  ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q <= REF_LAST);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  // R9
  no_cmd_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !issue);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BA_W     = 2,
  parameter logic [2:0]  BL_CODE  = 3'b011,
  parameter logic        BURST_IL = 1'b0,
  parameter logic [2:0]  CAS_LAT  = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  sd_cmd_e           cmd,
  output logic [3:0]        pins,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'({CAS_LAT, BURST_IL, BL_CODE});
  localparam logic [ADDR_W-1:0] PRE_ALL   = ADDR_W'(1) << 10;

  logic [3:0]        pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = '0;
    if (issue) begin
      unique case (cmd)
        CMD_PRE: addr_d = PRE_ALL;
        CMD_MRS: addr_d = MODE_WORD;
        default: addr_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= CMD_NOP;
      addr_q <= '0;
    end else begin
      pins_q <= issue ? cmd : CMD_NOP;
      addr_q <= addr_d;
    end
  end

  assign pins = pins_q;
  assign addr = addr_q;
  assign ba   = '0;

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q != CMD_NOP) |=> (pins_q == CMD_NOP));

  // R3
  pre_all_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q == CMD_PRE) |-> addr_q[10]);

  // R6
  mode_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q == CMD_MRS) |-> (addr_q >> 7) == '0);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS  = 4000,
  parameter int unsigned T_PAUSE_NS     = 200000,
  parameter int unsigned T_RP_NS        = 18,
  parameter int unsigned T_RC_NS        = 60,
  parameter int unsigned T_RSC_NS       = 15,
  parameter int unsigned NUM_REF        = 8,
  parameter bit          REF_BEFORE_MRS = 1'b1,
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned BA_W           = 2,
  parameter logic [2:0]  BL_CODE        = 3'b011,
  parameter logic        BURST_IL       = 1'b0,
  parameter logic [2:0]  CAS_LAT        = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done
);
  localparam int unsigned PAUSE_CYC = ns_to_cyc(T_PAUSE_NS, CLK_PERIOD_PS);
  localparam int unsigned RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned RC_CYC    = ns_to_cyc(T_RC_NS, CLK_PERIOD_PS);
  localparam int unsigned RSC_CYC   = ns_to_cyc(T_RSC_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC   = max2(max2(PAUSE_CYC, RP_CYC), max2(RC_CYC, RSC_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  logic             expired, issue, done;
  sd_cmd_e          cmd;
  logic [CNT_W-1:0] gap;
  logic [3:0]       pins;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(PAUSE_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(issue), .load_val(gap), .expired(expired)
  );

  sdram_init_fsm #(
    .CNT_W(CNT_W), .NUM_REF(NUM_REF), .REF_BEFORE_MRS(REF_BEFORE_MRS),
    .RP_CYC(RP_CYC), .RC_CYC(RC_CYC), .RSC_CYC(RSC_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .expired(expired), .issue(issue),
    .cmd(cmd), .gap(gap), .done(done)
  );

  sdram_init_cmd_enc #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .BL_CODE(BL_CODE),
    .BURST_IL(BURST_IL), .CAS_LAT(CAS_LAT)
  ) u_enc (
    .clk(clk), .rst_n(rst_n), .issue(issue), .cmd(cmd),
    .pins(pins), .addr(sd_addr), .ba(sd_ba)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;
  assign sd_cke    = 1'b1;
  assign init_done = done;
  assign sd_dqm    = ~done;

  // R2
  cke_dqm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (sd_cke && sd_dqm));

  // R9
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (pins == CMD_NOP && !sd_dqm));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int PER_PS = 4000;
  localparam int PAUSE  = 100;  // 400 ns / 4 ns
  localparam int RP     = 5;    // 20 ns / 4 ns
  localparam int RC     = 17;   // 66 ns / 4 ns = 16.5, rounded up
  localparam int RSC    = 3;    // 12 ns / 4 ns
  localparam int NREF   = 8;
  localparam int BL = 2, BT = 1, CL = 2;
  localparam int MODE = CL * 16 + BT * 8 + BL;
  localparam int NCYC = 512;

  localparam int NOP = 7, PRE = 2, REF = 1, MRS = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_done;
  logic [11:0] a_addr; logic [1:0] a_ba;
  logic b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_done;
  logic [11:0] b_addr; logic [1:0] b_ba;

  sdram_init_seq #(
    .CLK_PERIOD_PS(PER_PS), .T_PAUSE_NS(400), .T_RP_NS(20), .T_RC_NS(66), .T_RSC_NS(12),
    .NUM_REF(NREF), .REF_BEFORE_MRS(1'b1), .BL_CODE(3'(BL)), .BURST_IL(1'(BT)), .CAS_LAT(3'(CL))
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sd_cke(a_cke), .sd_dqm(a_dqm), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
    .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_addr(a_addr), .sd_ba(a_ba), .init_done(a_done)
  );

  sdram_init_seq #(
    .CLK_PERIOD_PS(PER_PS), .T_PAUSE_NS(400), .T_RP_NS(20), .T_RC_NS(66), .T_RSC_NS(12),
    .NUM_REF(NREF), .REF_BEFORE_MRS(1'b0), .BL_CODE(3'(BL)), .BURST_IL(1'(BT)), .CAS_LAT(3'(CL))
  ) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .sd_cke(b_cke), .sd_dqm(b_dqm), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
    .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_addr(b_addr), .sd_ba(b_ba), .init_done(b_done)
  );

  int exp_a [NCYC];
  int exp_b [NCYC];
  int done_a, done_b, mrs_a, mrs_b, pre_seen;
  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Build a schedule of command codes; returns the cycle at which done rises
  task automatic build(input bit ref_first, output int sched [NCYC], output int done_at, output int mrs_at);
    int t;
    for (int i = 0; i < NCYC; i++) sched[i] = NOP;
    t = PAUSE;
    sched[t] = PRE; t += RP;
    if (ref_first) begin
      for (int i = 0; i < NREF; i++) begin sched[t] = REF; t += RC; end
      sched[t] = MRS; mrs_at = t; t += RSC;
    end else begin
      sched[t] = MRS; mrs_at = t; t += RSC;
      for (int i = 0; i < NREF; i++) begin sched[t] = REF; t += RC; end
    end
    done_at = t;
  endtask

  function automatic string tag_of(int c, int n);
    if (c == PRE) return "R3";
    if (c == REF) return "R4";
    if (c == MRS) return "R6";
    if (n < PAUSE) return "R2";
    return "R8";
  endfunction

  task automatic cmp(input int n, input int sched [NCYC], input int done_at, input string who,
                     input logic [3:0] pins, input logic [11:0] addr, input logic [1:0] ba,
                     input logic cke, input logic dqm, input logic done);
    int ec, ea;
    ec = sched[n];
    ea = (ec == PRE) ? 1024 : (ec == MRS) ? MODE : 0;
    chk(int'(pins) == ec, tag_of(ec, n), {who, " cmd"}, pins, ec);
    chk(int'(addr) == ea && ba == 2'b00, tag_of(ec, n), {who, " addr/ba"}, {ba, addr}, ea);
    chk(cke == 1'b1, "R2", {who, " cke"}, cke, 1);
    chk(dqm == (n < done_at), n < done_at ? "R2" : "R9", {who, " dqm"}, dqm, n < done_at);
    chk(done == (n >= done_at), "R9", {who, " done"}, done, n >= done_at);
  endtask

  bit finished = 1'b0;

  initial begin
    build(1'b1, exp_a, done_a, mrs_a);
    build(1'b0, exp_b, done_b, mrs_b);
    pre_seen = -1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({a_cs, a_ras, a_cas, a_we} == 4'b0111 && a_addr == 0 && a_ba == 0, "R1", "reset bus", {a_cs, a_ras, a_cas, a_we}, 7);
    chk(a_cke && a_dqm && !a_done, "R1", "reset cke/dqm/done", {a_cke, a_dqm, a_done}, 3'b110);
    chk({b_cs, b_ras, b_cas, b_we} == 4'b0111 && b_cke && b_dqm && !b_done, "R1", "reset alt",
        {b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done}, 7'b0111110);
    rst_n = 1'b1;
    for (int n = 0; n < done_b + 20; n++) begin
      // sample cycle n (cycle 0 is before the first edge after release)
      cmp(n, exp_a, done_a, "ref-first", {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba, a_cke, a_dqm, a_done);
      cmp(n, exp_b, done_b, "mrs-first", {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba, b_cke, b_dqm, b_done);
      if (pre_seen < 0 && {a_cs, a_ras, a_cas, a_we} == 4'b0010) pre_seen = n;
      // R7: done exactly RSC after the mode write (ref-first)
      if (n == mrs_a + RSC - 1) chk(!a_done, "R7", "done before RSC", a_done, 0);
      if (n == mrs_a + RSC)     chk(a_done, "R7", "done at RSC", a_done, 1);
      // R7/R5: first refresh exactly RSC after the mode write (mrs-first)
      if (n == mrs_b + RSC) chk({b_cs, b_ras, b_cas, b_we} == 4'b0001, "R5", "refresh after mode write",
                                {b_cs, b_ras, b_cas, b_we}, 1);
      @(negedge clk);
    end
    // R10: pause and rounded refresh spacing
    chk(pre_seen == PAUSE, "R10", "precharge cycle", pre_seen, PAUSE);
    chk(done_a == PAUSE + RP + NREF * RC + RSC, "R10", "schedule length", done_a, PAUSE + RP + NREF * RC + RSC);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule